// File: doc/BRIEF.md
# Trace Buffer Scan Register Port

This block lets a debug host reach the register file of an on-chip trace buffer through a serial scan chain. A simplified test-port front end drives it with three strobes: capture, shift and update. It also supplies a serial input and takes a serial output. All three strobes are synchronous to the block clock. Each scan carries a 40-bit frame: a 32-bit data field, a 7-bit register address and a write flag.

A write frame changes the addressed register when update is strobed. A read frame latches the addressed register at update. The next capture loads that latched value into the data field, so it leaves the chain during the following scan. The block holds the trace RAM itself. The RAM data register reads and writes that memory through two wrapping pointers. Host software ends a read burst by addressing the identification register, so that no buffer word is lost. The chain responds only while a 5-bit chain-select register holds 0.

Top module: `trace_scan_port`

## Requirements
- R1: The frame is 40 bits and enters least significant bit first. Frame bits 0-31 hold data, bits 32-38 hold the address and bit 39 is the write flag. Each shift strobe moves the frame one place toward bit 0, `tdi_i` enters at bit 39, and `tdo_o` presents frame bit 0.
- R2: An update with write flag 1 writes the data field into the addressed writable register. The trigger count (address 7) and control word (address 8) appear on `trig_o` and `ctrl_o` in the cycle after the update strobe.
- R3: An update with write flag 0 latches the addressed register. The next capture strobe loads the latched value into frame bits 0-31 and clears frame bits 32-39. Write frames leave the latched value unchanged.
- R4: The read map is as follows. Address 0 returns the identification constant `ID_VALUE`. Address 1 returns `DEPTH` and address 2 returns 32. Address 3 returns `status_i` zero-extended. Addresses 5 and 6 return the read and write pointers, address 7 the trigger count and address 8 the control word.
- R5: A read of address 4 returns the RAM word at the read pointer and then advances the read pointer by one, wrapping from `DEPTH-1` to 0.
- R6: A write to address 4 stores the data field at the write pointer and advances the write pointer by one, wrapping from `DEPTH-1` to 0. A write to address 6 loads the write pointer.
- R7: Addresses 9 to 127 read as zero, and writes to them change nothing. Writes to addresses 0 to 3 are also ignored.
- R8: A write to address 5 sets the read pointer, and the very next read of address 4 uses the new value.
- R9: The strobes act only while the chain-select register holds 0. Otherwise `tdo_o` is 0 and no state changes. `chain_ld_i` loads the chain-select register from `chain_num_i`, and reset sets it to 31.
- R10: Reset clears the pointers, the trigger count, the control word, the latched read value and the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chain_ld_i | input | 1 | Load the chain-select register |
| chain_num_i | input | 5 | Chain number to load |
| capture_i | input | 1 | Capture strobe: loads the latched read value into the frame |
| shift_i | input | 1 | Shift strobe: moves the frame by one bit |
| update_i | input | 1 | Update strobe: executes the frame |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| status_i | input | STAT_W | Trace status flags, readable at address 3 |
| trig_o | output | 32 | Trigger count register |
| ctrl_o | output | 32 | Control register |

## Verification
The assertions check the per-cycle rules on every cycle:
- a shift moves the frame by exactly one place;
- a capture clears the address and flag field;
- each pointer steps by one on an access to the RAM data register;
- the control word stays stable unless an update writes address 8;
- the frame and outputs stay frozen while another chain is selected.

Some behaviours only the directed scenarios can show:
- the one-scan delay of read data;
- the order of words in a burst, with the pointers wrapping;
- the register map, including the read-only and unmapped addresses;
- that a pointer load takes effect before the next RAM read.

// File: rtl/tsp_pkg.sv
`timescale 1ns/1ps
package tsp_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 7;
  localparam int FRAME_W = DATA_W + ADDR_W + 1;
  localparam int CHAIN_W = 5;

  localparam logic [ADDR_W-1:0] A_IDENT = 7'd0;
  localparam logic [ADDR_W-1:0] A_DEPTH = 7'd1;
  localparam logic [ADDR_W-1:0] A_WIDTH = 7'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 7'd3;
  localparam logic [ADDR_W-1:0] A_DATA  = 7'd4;
  localparam logic [ADDR_W-1:0] A_RPTR  = 7'd5;
  localparam logic [ADDR_W-1:0] A_WPTR  = 7'd6;
  localparam logic [ADDR_W-1:0] A_TRIG  = 7'd7;
  localparam logic [ADDR_W-1:0] A_CTRL  = 7'd8;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/tsp_chain_sel.sv
`timescale 1ns/1ps
module tsp_chain_sel
  import tsp_pkg::*;
#(
  parameter logic [CHAIN_W-1:0] MY_CHAIN = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_i,
  input  logic [CHAIN_W-1:0] num_i,
  output logic               sel_o
);
  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   chain_q <= '1;
    else if (ld_i) chain_q <= num_i;
  end

  assign sel_o = (chain_q == MY_CHAIN);
endmodule

// File: rtl/tsp_shifter.sv
`timescale 1ns/1ps
module tsp_shifter
  import tsp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic               shift_i,
  input  logic               tdi_i,
  input  logic [DATA_W-1:0]  cap_data_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int TOP_W = FRAME_W - DATA_W;

  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (cap_i)      sr_q <= {{TOP_W{1'b0}}, cap_data_i};
    else if (shift_i)    sr_q <= {tdi_i, sr_q[FRAME_W-1:1]};
  end

  assign frame_o = sr_q;
endmodule

// File: rtl/tsp_regfile.sv
`timescale 1ns/1ps
module tsp_regfile
  import tsp_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          STAT_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h5C4A_0001,
  localparam int         PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [STAT_W-1:0]  status_i,
  output logic [DATA_W-1:0]  hold_o,
  output logic [PTR_W-1:0]   rd_ptr_o,
  output logic [PTR_W-1:0]   wr_ptr_o,
  output logic [DATA_W-1:0]  trig_o,
  output logic [DATA_W-1:0]  ctrl_o
);
  frame_t             fr;
  logic [DATA_W-1:0]  mem [DEPTH];
  logic [DATA_W-1:0]  rd_val;
  logic [DATA_W-1:0]  hold_q, trig_q, ctrl_q;
  logic [PTR_W-1:0]   rd_ptr_q, wr_ptr_q;
  logic               do_wr, do_rd;

  assign fr    = frame_t'(frame_i);
  assign do_wr = upd_i &  fr.wr;
  assign do_rd = upd_i & ~fr.wr;

  always_comb begin
    unique case (fr.addr)
      A_IDENT: rd_val = ID_VALUE;
      A_DEPTH: rd_val = DATA_W'(DEPTH);
      A_WIDTH: rd_val = DATA_W'(DATA_W);
      A_STAT:  rd_val = DATA_W'(status_i);
      A_DATA:  rd_val = mem[rd_ptr_q];
      A_RPTR:  rd_val = DATA_W'(rd_ptr_q);
      A_WPTR:  rd_val = DATA_W'(wr_ptr_q);
      A_TRIG:  rd_val = trig_q;
      A_CTRL:  rd_val = ctrl_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      trig_q   <= '0;
      ctrl_q   <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
    end else if (do_wr) begin
      case (fr.addr)
        A_DATA:  wr_ptr_q <= wr_ptr_q + PTR_W'(1);
        A_RPTR:  rd_ptr_q <= fr.data[PTR_W-1:0];
        A_WPTR:  wr_ptr_q <= fr.data[PTR_W-1:0];
        A_TRIG:  trig_q   <= fr.data;
        A_CTRL:  ctrl_q   <= fr.data;
        default: ;
      endcase
    end else if (do_rd) begin
      hold_q <= rd_val;
      if (fr.addr == A_DATA) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
    end
  end

  // trace RAM, no reset on storage
  always_ff @(posedge clk_i) begin
    if (do_wr && fr.addr == A_DATA) mem[wr_ptr_q] <= fr.data;
  end

  assign hold_o   = hold_q;
  assign rd_ptr_o = rd_ptr_q;
  assign wr_ptr_o = wr_ptr_q;
  assign trig_o   = trig_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/trace_scan_port.sv
`timescale 1ns/1ps
module trace_scan_port
  import tsp_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          STAT_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h5C4A_0001,
  localparam int         PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               chain_ld_i,
  input  logic [CHAIN_W-1:0] chain_num_i,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  input  logic [STAT_W-1:0]  status_i,
  output logic [DATA_W-1:0]  trig_o,
  output logic [DATA_W-1:0]  ctrl_o
);
  logic               chain_sel;
  logic               cap_fire, shf_fire, upd_fire;
  logic [FRAME_W-1:0] frame;
  logic [DATA_W-1:0]  hold;
  logic [PTR_W-1:0]   rd_ptr, wr_ptr;

  tsp_chain_sel #(.MY_CHAIN('0)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (chain_ld_i),
    .num_i  (chain_num_i),
    .sel_o  (chain_sel)
  );

  assign cap_fire = capture_i & chain_sel;
  assign shf_fire = shift_i   & chain_sel;
  assign upd_fire = update_i  & chain_sel;

  tsp_shifter u_shf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap_fire),
    .shift_i    (shf_fire),
    .tdi_i      (tdi_i),
    .cap_data_i (hold),
    .frame_o    (frame)
  );

  tsp_regfile #(
    .DEPTH    (DEPTH),
    .STAT_W   (STAT_W),
    .ID_VALUE (ID_VALUE)
  ) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd_fire),
    .frame_i  (frame),
    .status_i (status_i),
    .hold_o   (hold),
    .rd_ptr_o (rd_ptr),
    .wr_ptr_o (wr_ptr),
    .trig_o   (trig_o),
    .ctrl_o   (ctrl_o)
  );

  assign tdo_o = chain_sel & frame[0];
endmodule

// File: rtl/tsp_checker.sv
`timescale 1ns/1ps
module tsp_checker #(
  parameter int FW = 40,
  parameter int DW = 32,
  parameter int AW = 7,
  parameter int PW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_i,
  input logic          cap_i,
  input logic          shf_i,
  input logic          upd_i,
  input logic          raw_upd_i,
  input logic [FW-1:0] frame_i,
  input logic [PW-1:0] rd_ptr_i,
  input logic [PW-1:0] wr_ptr_i,
  input logic [DW-1:0] trig_i,
  input logic [DW-1:0] ctrl_i
);
  logic          f_wr;
  logic [AW-1:0] f_addr;
  assign f_wr   = frame_i[FW-1];
  assign f_addr = frame_i[FW-2 -: AW];

  a_r1_shift_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shf_i && !cap_i |=> frame_i[FW-2:0] == $past(frame_i[FW-1:1]));

  a_r3_capture_clears_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> frame_i[FW-1:DW] == '0);

  a_r5_rptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !f_wr && f_addr == AW'(4) |=> rd_ptr_i == $past(rd_ptr_i) + PW'(1));

  a_r6_wptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && f_wr && f_addr == AW'(4) |=> wr_ptr_i == $past(wr_ptr_i) + PW'(1));

  a_r7_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_i && f_wr && f_addr == AW'(8)) |=> $stable(ctrl_i));

  a_r9_frozen_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(frame_i));

  a_r9_update_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_upd_i && !sel_i |=> $stable(trig_i) && $stable(rd_ptr_i) && $stable(wr_ptr_i));
endmodule

bind trace_scan_port tsp_checker #(
  .FW(tsp_pkg::FRAME_W), .DW(tsp_pkg::DATA_W), .AW(tsp_pkg::ADDR_W), .PW(PTR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (chain_sel),
  .cap_i     (cap_fire),
  .shf_i     (shf_fire),
  .upd_i     (upd_fire),
  .raw_upd_i (update_i),
  .frame_i   (frame),
  .rd_ptr_i  (rd_ptr),
  .wr_ptr_i  (wr_ptr),
  .trig_i    (trig_o),
  .ctrl_i    (ctrl_o)
);

// File: tb/sim_trace_scan_port.sv
`timescale 1ns/1ps
module sim_trace_scan_port;
  localparam int          DEPTH = 16;
  localparam logic [31:0] IDV   = 32'h5C4A_0001;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        chain_ld_i = 1'b0;
  logic [4:0]  chain_num_i = '0;
  logic        capture_i = 1'b0, shift_i = 1'b0, update_i = 1'b0, tdi_i = 1'b0;
  logic        tdo_o;
  logic [3:0]  status_i = 4'hA;
  logic [31:0] trig_o, ctrl_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  trace_scan_port #(.DEPTH(DEPTH), .STAT_W(4), .ID_VALUE(IDV)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [39:0] last_out;

  // capture, 40 shifts, update; returns the bits shifted out
  task automatic scan(input logic [31:0] d, input logic [6:0] a, input bit w,
                      output logic [31:0] got);
    logic [39:0] fin;
    fin = {w, a, d};
    capture_i = 1'b1;
    @(negedge clk_i);
    capture_i = 1'b0;
    for (int k = 0; k < 40; k++) begin
      last_out[k] = tdo_o;
      tdi_i   = fin[k];
      shift_i = 1'b1;
      @(negedge clk_i);
    end
    shift_i  = 1'b0;
    update_i = 1'b1;
    @(negedge clk_i);
    update_i = 1'b0;
    got = last_out[31:0];
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    logic [31:0] g;
    scan(d, a, 1'b1, g);
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    logic [31:0] g;
    scan(32'h0, a, 1'b0, g);
    scan(32'h0, 7'd0, 1'b0, v);
  endtask

  task automatic select(input logic [4:0] n);
    chain_num_i = n;
    chain_ld_i  = 1'b1;
    @(negedge clk_i);
    chain_ld_i  = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] g;
    chk("R10 ctrl after reset", ctrl_o, 32'h0);
    chk("R10 trig after reset", trig_o, 32'h0);
    chk("R9 tdo unselected at reset", {31'h0, tdo_o}, 32'h0);
    select(5'd0);
    scan(32'h0, 7'd5, 1'b0, g);
    chk("R10 held value after reset", g, 32'h0);
    scan(32'h0, 7'd6, 1'b0, g);
    chk("R10 read pointer after reset", g, 32'h0);
    scan(32'h0, 7'd0, 1'b0, g);
    chk("R10 write pointer after reset", g, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    rd(7'd0, v); chk("R4 identification", v, IDV);
    rd(7'd1, v); chk("R4 depth", v, DEPTH);
    rd(7'd2, v); chk("R4 width", v, 32);
    rd(7'd3, v); chk("R4 status", v, 32'hA);
    chk("R3 top frame bits zero after capture", {24'h0, last_out[39:32]}, 32'h0);
  endtask

  task automatic t_write;
    logic [31:0] v;
    wr(7'd7, 32'h8000_0001);
    chk("R2 trig output", trig_o, 32'h8000_0001);
    wr(7'd8, 32'h0000_00C3);
    chk("R2 ctrl output", ctrl_o, 32'h0000_00C3);
    rd(7'd7, v); chk("R1 bit order on trig readback", v, 32'h8000_0001);
    rd(7'd8, v); chk("R4 ctrl readback", v, 32'h0000_00C3);
    // a write does not replace the held read value
    wr(7'd7, 32'h0000_1234);
    scan(32'h0, 7'd0, 1'b0, v);
    chk("R3 held value kept over write", v, IDV);
  endtask

  task automatic t_ram;
    logic [31:0] v;
    for (int i = 0; i < 5; i++) wr(7'd4, 32'hA000_0000 + i);
    rd(7'd6, v); chk("R6 write pointer after 5", v, 5);
    wr(7'd5, 32'h0);
    scan(32'h0, 7'd4, 1'b0, v);
    for (int i = 0; i < 5; i++) begin
      scan(32'h0, (i < 4) ? 7'd4 : 7'd0, 1'b0, v);
      chk("R5 burst word", v, 32'hA000_0000 + i);
    end
    rd(7'd5, v); chk("R5 read pointer after burst", v, 5);
    wr(7'd5, 32'h2);
    rd(7'd4, v); chk("R8 pointer load before read", v, 32'hA000_0002);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(7'd6, DEPTH - 1);
    wr(7'd4, 32'hBEEF_000F);
    wr(7'd4, 32'hBEEF_0000);
    rd(7'd6, v); chk("R6 write pointer wrap", v, 1);
    wr(7'd5, DEPTH - 1);
    scan(32'h0, 7'd4, 1'b0, v);
    scan(32'h0, 7'd4, 1'b0, v);
    chk("R5 word at last slot", v, 32'hBEEF_000F);
    scan(32'h0, 7'd0, 1'b0, v);
    chk("R5 word after wrap", v, 32'hBEEF_0000);
    rd(7'd5, v); chk("R5 read pointer wrap", v, 1);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(7'd9,   32'hFFFF_FFFF);
    wr(7'd127, 32'hFFFF_FFFF);
    chk("R7 ctrl untouched", ctrl_o, 32'h0000_00C3);
    chk("R7 trig untouched", trig_o, 32'h0000_1234);
    rd(7'd9,   v); chk("R7 addr 9 reads zero", v, 0);
    rd(7'd100, v); chk("R7 addr 100 reads zero", v, 0);
    wr(7'd0, 32'h1111_1111);
    wr(7'd1, 32'h1111_1111);
    rd(7'd0, v); chk("R7 ident read-only", v, IDV);
    rd(7'd1, v); chk("R7 depth read-only", v, DEPTH);
  endtask

  task automatic t_chain;
    logic [31:0] v;
    select(5'd3);
    scan(32'hFFFF_FFFF, 7'd8, 1'b1, v);
    chk("R9 tdo quiet while unselected", v, 0);
    chk("R9 ctrl unchanged while unselected", ctrl_o, 32'h0000_00C3);
    select(5'd0);
    rd(7'd8, v); chk("R9 ctrl after reselect", v, 32'h0000_00C3);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_map;
    t_write;
    t_ram;
    t_wrap;
    t_unmapped;
    t_chain;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule